// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects sixteen maskable interrupt requests and one nonmaskable request, passes each through a two-flop synchronizer and an edge detector, and records every rising request in a pending-flag register. It records the request whether or not the source is currently allowed to interrupt. A mask register and a single global disable bit decide which pending sources may interrupt. A fixed-priority picker selects the winner and forms its program vector inside a relocatable 2K-word page.

The CPU sees a registered take request that carries the source number and vector. The CPU answers with an acknowledge, which clears that source's flag, sets the global disable bit and returns a one-cycle acknowledge report. A software-trap input does the same work for a number the CPU supplies. Enable, disable and return-with-enable strobes drive the global bit. An instruction-complete strobe closes the one-instruction shadow that follows an enable or disable. A repeat-lock input holds off every request, including the nonmaskable one.

A small register port reads and writes the flag register, the mask register and the vector page pointer.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the flags, the mask and the page pointer read 0, take_o, ack_vld_o and take_vec_o are 0, and the global disable bit is set, so a pending unmasked source is not taken.
- R2: A vector is the 5-bit page pointer in bits 15:11, zeros in bits 10:6, the 5-bit number in bits 5:1 and 0 in bit 0. Source INTk (k = 1..16, bit k-1 of irq_i and of the flag register) has number k. The software TRAP has number 17 and the nonmaskable interrupt has number 18.
- R3: A rising edge on irq_i[k-1] sets flag bit k-1 whatever the mask and global disable are. The flag is readable after the third rising clock edge that samples the request high. take_o follows one edge later if the source is eligible.
- R4: Writing the flag register clears each flag whose write-data bit is 1 and leaves the others unchanged. A request that sets a flag in the same cycle as a write-one clear of it leaves the flag set.
- R5: Register addresses (reg_addr_i): 6 = flags, 4 = mask (16 bits), 7 = page pointer (bits 4:0). Reads return current contents, and any other address reads 0.
- R6: A maskable source is taken only when its mask bit is 1 and the global disable bit is 0. The mask and the global disable bit do not hold off the nonmaskable interrupt.
- R7: Priority from highest: nonmaskable, then INT1, INT2, through INT16.
- R8: ack_i while take_o is 1 clears the presented source's pending state and sets the global disable bit. On the next cycle it gives one cycle of ack_vld_o with ack_num_o and ack_vec_o equal to the presented number and vector, and take_o is 0.
- R9: trap_i with trap_num_i = n clears flag n (for n in 1..16) and sets the global disable bit. On the next cycle it reports ack_vld_o with number n and its vector, and n = 17 gives offset 0x22.
- R10: dis_i sets the global disable bit, and ena_i or rete_i clears it.
- R11: After ena_i or dis_i, take_o stays 0 until insn_i has been seen once. It can rise one cycle after that.
- R12: While rpt_lock_i is 1, take_o is 0 from the next cycle on, for the nonmaskable interrupt as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Maskable requests, bit k-1 is INTk, rising edge active |
| nmi_i | input | 1 | Nonmaskable request, rising edge active |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| take_o | output | 1 | Interrupt take request to the CPU |
| take_num_o | output | 5 | Number of the presented interrupt |
| take_vec_o | output | 16 | Vector of the presented interrupt |
| ack_i | input | 1 | CPU accepts the presented interrupt |
| trap_i | input | 1 | Software trap strobe |
| trap_num_i | input | 5 | Software trap number |
| ena_i | input | 1 | Global enable command |
| dis_i | input | 1 | Global disable command |
| rete_i | input | 1 | Return with enable |
| insn_i | input | 1 | Instruction-complete strobe |
| rpt_lock_i | input | 1 | Repeat-loop lock, holds off all requests |
| ack_vld_o | output | 1 | One-cycle acknowledge report |
| ack_num_o | output | 5 | Number of the acknowledged interrupt |
| ack_vec_o | output | 16 | Vector of the acknowledged interrupt |

## Verification
The hardest case to reach is a write-one clear landing on the exact edge at which a synchronized request sets the same flag. The bench raises the request, counts the two synchronizer edges, and times the register write for the third edge. It then reads the flag back to confirm the set won. The one-instruction shadow is also awkward to reach, because a source must already be pending and eligible when the enable arrives. The bench parks a pending flag behind the global disable bit and issues the enable. It then holds back insn_i for several cycles before releasing it, so the edge at which take_o first rises is exposed.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int NUM_SRC = 16;
  localparam int NUM_W   = 5;
  localparam int ADDR_W  = 16;
  localparam int PAGE_W  = 11;
  localparam int PTR_W   = ADDR_W - PAGE_W;
  localparam int PAD_W   = PAGE_W - NUM_W - 1;
  localparam int SYNC_N  = 2;
  localparam int REG_AW  = 4;
  localparam int DATA_W  = 16;

  localparam logic [NUM_W-1:0] NUM_TRAP = NUM_W'(17);
  localparam logic [NUM_W-1:0] NUM_NMI  = NUM_W'(18);

  localparam logic [REG_AW-1:0] ADR_MASK = REG_AW'(4);
  localparam logic [REG_AW-1:0] ADR_FLAG = REG_AW'(6);
  localparam logic [REG_AW-1:0] ADR_PTR  = REG_AW'(7);

  function automatic logic [ADDR_W-1:0] vec_of(logic [PTR_W-1:0] p, logic [NUM_W-1:0] n);
    return {p, {PAD_W{1'b0}}, n, 1'b0};
  endfunction

  function automatic logic [NUM_SRC-1:0] num_bit(logic [NUM_W-1:0] n);
    logic [NUM_SRC-1:0] b;
    for (int i = 0; i < NUM_SRC; i++) b[i] = (n == NUM_W'(i + 1));
    return b;
  endfunction
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
      dly_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      dly_q <= stg_q[STAGES-1];
    end
  end

  assign rise_o = stg_q[STAGES-1] & ~dly_q;
endmodule

// File: rtl/irq_flags.sv
`timescale 1ns/1ps
module irq_flags #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  // set has precedence over any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;

  // R3
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));

  // R4
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(flag_o) & ~flag_o) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               gdis_i,
  input  logic               nmi_i,
  output logic               any_o,
  output logic [NUM_W-1:0]   num_o
);
  logic [NUM_SRC-1:0] cand, grant;
  logic               found;
  logic [NUM_W-1:0]   mnum;

  assign cand = gdis_i ? '0 : (flag_i & mask_i);

  // lowest index wins
  always_comb begin
    grant = '0;
    found = 1'b0;
    mnum  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!found && cand[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        mnum     = NUM_W'(i + 1);
      end
    end
  end

  assign any_o = nmi_i | found;
  assign num_o = nmi_i ? NUM_NMI : mnum;

  // R7
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  // R6
  masked_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant & ~(flag_i & mask_i)) == '0);
endmodule

// File: rtl/irq_vec_ctrl.sv
`timescale 1ns/1ps
module irq_vec_ctrl
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               nmi_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               take_o,
  output logic [NUM_W-1:0]   take_num_o,
  output logic [ADDR_W-1:0]  take_vec_o,
  input  logic               ack_i,
  input  logic               trap_i,
  input  logic [NUM_W-1:0]   trap_num_i,
  input  logic               ena_i,
  input  logic               dis_i,
  input  logic               rete_i,
  input  logic               insn_i,
  input  logic               rpt_lock_i,
  output logic               ack_vld_o,
  output logic [NUM_W-1:0]   ack_num_o,
  output logic [ADDR_W-1:0]  ack_vec_o
);
  logic [NUM_SRC:0]   rise;
  logic [NUM_SRC-1:0] flags, flag_clr, mask_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               gdis_q, shadow_q, nmi_pend_q;
  logic               take_q, ack_vld_q;
  logic [NUM_W-1:0]   tnum_q, ack_num_q, pick_num, ack_num_d;
  logic [ADDR_W-1:0]  tvec_q, ack_vec_q;
  logic               pick_any, ack_fire, take_d;
  logic               wr_flag, wr_mask, wr_ptr;

  irq_sync #(.W(NUM_SRC + 1), .STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .d_i({nmi_i, irq_i}), .rise_o(rise)
  );

  assign wr_flag  = reg_we_i && reg_addr_i == ADR_FLAG;
  assign wr_mask  = reg_we_i && reg_addr_i == ADR_MASK;
  assign wr_ptr   = reg_we_i && reg_addr_i == ADR_PTR;
  assign ack_fire = ack_i & take_q;
  assign ack_num_d = ack_fire ? tnum_q : trap_num_i;

  assign flag_clr = (wr_flag ? reg_wdata_i[NUM_SRC-1:0] : '0)
                  | ((ack_fire | trap_i) ? num_bit(ack_num_d) : '0);

  irq_flags #(.W(NUM_SRC)) u_flags (
    .clk_i, .rst_ni, .set_i(rise[NUM_SRC-1:0]), .clr_i(flag_clr), .flag_o(flags)
  );

  irq_pick u_pick (
    .clk_i, .rst_ni, .flag_i(flags), .mask_i(mask_q), .gdis_i(gdis_q),
    .nmi_i(nmi_pend_q), .any_o(pick_any), .num_o(pick_num)
  );

  // commands and acks in flight suppress the take for one cycle
  assign take_d = pick_any & ~rpt_lock_i & ~shadow_q & ~ack_i & ~trap_i & ~ena_i & ~dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= '0;
      ptr_q      <= '0;
      gdis_q     <= 1'b1;
      shadow_q   <= 1'b0;
      nmi_pend_q <= 1'b0;
      take_q     <= 1'b0;
      tnum_q     <= '0;
      tvec_q     <= '0;
      ack_vld_q  <= 1'b0;
      ack_num_q  <= '0;
      ack_vec_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata_i[NUM_SRC-1:0];
      if (wr_ptr)  ptr_q  <= reg_wdata_i[PTR_W-1:0];

      if (ack_fire || trap_i || dis_i) gdis_q <= 1'b1;
      else if (ena_i || rete_i)        gdis_q <= 1'b0;

      if (ena_i || dis_i) shadow_q <= 1'b1;
      else if (insn_i)    shadow_q <= 1'b0;

      if (rise[NUM_SRC])                        nmi_pend_q <= 1'b1;
      else if (ack_fire && tnum_q == NUM_NMI)   nmi_pend_q <= 1'b0;

      take_q <= take_d;
      tnum_q <= pick_num;
      tvec_q <= vec_of(ptr_q, pick_num);

      ack_vld_q <= ack_fire | trap_i;
      if (ack_fire || trap_i) begin
        ack_num_q <= ack_num_d;
        ack_vec_q <= vec_of(ptr_q, ack_num_d);
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADR_FLAG: reg_rdata_o = DATA_W'(flags);
      ADR_MASK: reg_rdata_o = DATA_W'(mask_q);
      ADR_PTR:  reg_rdata_o = DATA_W'(ptr_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign take_o     = take_q;
  assign take_num_o = take_q ? tnum_q : '0;
  assign take_vec_o = take_q ? tvec_q : '0;
  assign ack_vld_o  = ack_vld_q;
  assign ack_num_o  = ack_num_q;
  assign ack_vec_o  = ack_vec_q;

  // R12
  rpt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_lock_i |=> !take_o);

  // R11
  shadow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i || dis_i) |=> (!take_o && shadow_q));

  // R8
  ack_gdis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire |=> (gdis_q && !take_o && ack_vld_o));

  // R10
  rete_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rete_i && !dis_i && !ack_fire && !trap_i) |=> !gdis_q);
endmodule

// File: tb/irq_vec_ctrl_test.sv
`timescale 1ns/1ps
module irq_vec_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        nmi = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        take;
  logic [4:0]  tnum;
  logic [15:0] tvec;
  logic        ack = 0, trap = 0, ena = 0, dis = 0, rete = 0, insn = 0, rpt = 0;
  logic [4:0]  trap_num = '0;
  logic        avld;
  logic [4:0]  anum;
  logic [15:0] avec;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_i(nmi),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .take_o(take), .take_num_o(tnum), .take_vec_o(tvec),
    .ack_i(ack), .trap_i(trap), .trap_num_i(trap_num),
    .ena_i(ena), .dis_i(dis), .rete_i(rete), .insn_i(insn), .rpt_lock_i(rpt),
    .ack_vld_o(avld), .ack_num_o(anum), .ack_vec_o(avec)
  );

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int vexp(int p, int n);
    return (p << 11) | (n << 1);
  endfunction

  task automatic wr(int a, int d);
    addr = 4'(a); wdata = 16'(d); we = 1'b1; step(); we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    addr = 4'(a); #0.5; d = int'(rdata);
  endtask

  task automatic enable();
    ena = 1; step(); ena = 0; insn = 1; step(); insn = 0;
  endtask

  task automatic do_ack();
    ack = 1; step(); ack = 0;
  endtask

  task automatic fire(logic [15:0] m);
    irq = m; step(); irq = '0;
  endtask

  initial begin
    #1ms;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d;
    step(3); rst_n = 1'b1; step();
    // R1 reset state
    chk("R1 take", take, 0); chk("R1 vec", tvec, 0); chk("R1 avld", avld, 0);
    rd(6, d); chk("R1 flags", d, 0);
    rd(4, d); chk("R1 mask", d, 0);
    rd(7, d); chk("R1 ptr", d, 0);
    wr(4, 16'hFFFF); fire(16'h0001); step(5);
    chk("R1 gdis blocks", take, 0);
    wr(6, 16'hFFFF);

    // R5 register map
    wr(4, 16'hA5C3); rd(4, d); chk("R5 mask", d, 16'hA5C3);
    wr(7, 16'hFFFF); rd(7, d); chk("R5 ptr", d, 16'h001F);
    rd(0, d); chk("R5 other", d, 0);
    wr(4, 16'hFFFF);

    // R3 latency: flag after 3 edges, take one later
    wr(7, 0); enable();
    irq = 16'h0001; step(); irq = '0; step(2);
    rd(6, d); chk("R3 flag at edge3", d, 1); chk("R3 no take yet", take, 0);
    step(); chk("R3 take at edge4", take, 1);
    // R2 ptr=0 / INT1 and relocation
    chk("R2 vec int1", tvec, vexp(0, 1));
    do_ack();

    // R2 R8 sweep every source with varying page pointer
    for (int k = 1; k <= 16; k++) begin
      wr(7, k); enable(); fire(16'(1 << (k - 1))); step(5);
      chk("R8 take", take, 1); chk("R7 num", tnum, k); chk("R2 vec", tvec, vexp(k, k));
      do_ack();
      chk("R8 avld", avld, 1); chk("R8 anum", anum, k); chk("R8 avec", avec, vexp(k, k));
      chk("R8 take low", take, 0);
      rd(6, d); chk("R8 flag cleared", d, 0);
      step(); chk("R8 avld pulse", avld, 0);
    end
    wr(7, 1); enable(); fire(16'h0001); step(5);
    chk("R2 page1 vec", tvec, 16'h0802); do_ack();

    // R7 all pairs
    wr(7, 0);
    for (int i = 1; i <= 16; i++) begin
      for (int j = i + 1; j <= 16; j++) begin
        fire(16'((1 << (i - 1)) | (1 << (j - 1)))); step(4);
        enable(); step();
        chk("R7 first", tnum, i); do_ack();
        enable(); step();
        chk("R7 second", tnum, j); do_ack();
      end
    end

    // R4 write zero, write one, same-cycle set wins
    fire(16'h0180); step(4);
    wr(6, 0); rd(6, d); chk("R4 zero write", d, 16'h0180);
    wr(6, 16'h0080); rd(6, d); chk("R4 one clears", d, 16'h0100);
    wr(6, 16'hFFFF);
    irq = 16'h0200; step(); irq = '0; step();
    addr = 4'd6; wdata = 16'h0200; we = 1; step(); we = 0;
    rd(6, d); chk("R4 set wins", d, 16'h0200);
    wr(6, 16'hFFFF);

    // R6 mask, R10 disable, NMI bypass
    wr(4, 0); enable(); fire(16'h0004); step(5);
    chk("R6 masked no take", take, 0);
    rd(6, d); chk("R3 flag despite mask", d, 4);
    wr(4, 16'hFFFF); step(2);
    chk("R6 unmasked take", take, 1); chk("R6 num", tnum, 3);
    dis = 1; step(); dis = 0; insn = 1; step(); insn = 0; step();
    chk("R10 dis blocks", take, 0);
    nmi = 1; step(); nmi = 0; step(5);
    chk("R6 nmi bypass", take, 1); chk("R7 nmi first", tnum, 18);
    chk("R2 nmi vec", tvec, 16'h0024);
    do_ack(); chk("R8 nmi anum", anum, 18); step(2);
    chk("R8 gdis after nmi", take, 0);
    rete = 1; step(); rete = 0; step();
    chk("R10 rete enables", take, 1); chk("R10 num", tnum, 3);
    do_ack();

    // R11 shadow after enable
    fire(16'h0008); step(4);
    ena = 1; step(); ena = 0; step(3);
    chk("R11 shadow holds", take, 0);
    insn = 1; step(); insn = 0;
    chk("R11 edge of insn", take, 0);
    step(); chk("R11 after insn", take, 1);

    // R12 repeat lock incl. NMI
    rpt = 1; step(); chk("R12 lock", take, 0);
    nmi = 1; step(); nmi = 0; step(5);
    chk("R12 nmi held", take, 0);
    rpt = 0; step(); chk("R12 release", take, 1); chk("R12 nmi num", tnum, 18);
    do_ack(); rete = 1; step(); rete = 0; step();
    chk("R12 int4 after", tnum, 4); do_ack();

    // R9 software trap
    wr(7, 2); fire(16'h0020); step(4);
    trap_num = 5'd6; trap = 1; step(); trap = 0;
    chk("R9 avld", avld, 1); chk("R9 anum", anum, 6); chk("R9 avec", avec, vexp(2, 6));
    rd(6, d); chk("R9 flag cleared", d, 0);
    enable();
    trap_num = 5'd17; trap = 1; step(); trap = 0;
    chk("R9 trap vec", avec, 16'h1022);
    fire(16'h0040); step(5);
    chk("R9 trap sets gdis", take, 0);
    rete = 1; step(); rete = 0; step();
    chk("R9 then rete", tnum, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule